// File: doc/BRIEF.md
# Lockable FIFO Way Replacement

This block decides which way of one set of a set-associative cache receives the next line fill. It holds, for every way, a valid flag, a dirty flag, a lock flag, a 3-bit age and the line address of the resident line. A single mode input selects whether four or eight ways are in use. When a fill is requested, the block names the victim way at once, combinationally. It also raises a flag when that victim holds modified data, so that the surrounding cache can write the line back first. The new state is taken at the next clock edge.

Two programmable address windows can pin lines into the cache. A line filled from an address inside an enabled window is marked locked, and a locked line is never chosen as a victim. Turning a window off only stops further pinning: lines that are already locked stay locked. They are released by an explicit unlock over an address range. A whole-set invalidate drops every valid flag. Tag comparison, the data array and the write-back transfer belong to the surrounding cache.

Top module: `lkfifo_way_repl`

## Requirements
- R1: With `mode_eight`=0 only ways 0..3 are used: a victim index is always below 4 and `way_valid[7:4]` stays 0; with `mode_eight`=1 ways 0..7 are used.
- R2: If any active way is invalid, the victim is the lowest-indexed invalid active way.
- R3: If no active way is invalid, the victim is the unlocked active way with the largest age, ties going to the lowest index. On an accepted fill, the victim's age becomes 0. Every other valid, unlocked, active way whose age is below (active ways − 1) ages by one. Ages appear on `way_age`, 3 bits per way, with way w at bits [3w+2:3w].
- R4: `victim_dirty` is 1 only when the chosen victim is valid and dirty. A fill sets the new line's dirty flag to `fill_dirty`. A mark request sets the dirty flag of a valid, active way.
- R5: A fill whose address lies in [base, base+size) of an enabled window (either of the two) leaves that line locked. Locked lines are never victims.
- R6: Clearing a window's enable leaves the lock flags of resident lines unchanged.
- R7: An unlock request clears the lock flag of every valid line whose address lies in [unlock_addr, unlock_addr+unlock_size).
- R8: When every active way is both valid and locked, `victim_none` is 1 and a fill changes no state.
- R9: `inv_all` clears every valid flag by the next cycle. It takes priority over a fill in the same cycle. The priority order is invalidate, then fill, then unlock, then mark.
- R10: After reset, all ways are invalid, unlocked and clean, and all ages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_eight | input | 1 | 0: four ways active, 1: eight ways active |
| fill_req | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Line address of the incoming line |
| fill_dirty | input | 1 | Incoming line is already modified |
| mark_req | input | 1 | Set the dirty flag of one way |
| mark_way | input | IDX_W | Way to mark dirty |
| unlock_req | input | 1 | Release locks in an address range |
| unlock_addr | input | ADDR_W | Start of the unlock range |
| unlock_size | input | ADDR_W | Length of the unlock range |
| inv_all | input | 1 | Invalidate every way |
| lk0_en | input | 1 | Window 0 enable |
| lk0_base | input | ADDR_W | Window 0 start |
| lk0_size | input | ADDR_W | Window 0 length |
| lk1_en | input | 1 | Window 1 enable |
| lk1_base | input | ADDR_W | Window 1 start |
| lk1_size | input | ADDR_W | Window 1 length |
| victim_way | output | IDX_W | Chosen way for the current fill |
| victim_dirty | output | 1 | Chosen victim holds modified data |
| victim_none | output | 1 | No way may be replaced |
| way_valid | output | MAX_WAYS | Valid flag per way |
| way_dirty | output | MAX_WAYS | Dirty flag per way |
| way_locked | output | MAX_WAYS | Lock flag per way |
| way_age | output | MAX_WAYS*AGE_W | Age per way, packed |

## Verification
Long fill streams are run in both modes. They mix ordinary addresses, addresses inside each lock window, interleaved dirty marks, a window disable and a range unlock. The first fills of each stream separate lowest-free selection from oldest-age selection. Later fills show whether locked ways are skipped and whether ages saturate at the mode's limit. A directed case locks every way in four-way mode and then offers a fill, which tells a refused fill apart from one that silently evicts a pinned line. A fill raised in the same cycle as the invalidate shows which of the two wins.

// File: rtl/lkfifo_pkg.sv
package lkfifo_pkg;
    // Operation applied to the set in one cycle, after priority resolution
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_INV,
        OP_FILL,
        OP_UNLOCK,
        OP_MARK
    } set_op_e;
endpackage

// File: rtl/lkfifo_addr_window.sv
module lkfifo_addr_window #(
    parameter int ADDR_W = 16
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    output logic              hit
);
    // One extra bit so that base + size never wraps
    logic [ADDR_W:0] limit;

    assign limit = {1'b0, base} + {1'b0, size};
    assign hit   = enable && (addr >= base) && ({1'b0, addr} < limit);
endmodule

// File: rtl/lkfifo_victim_pick.sv
module lkfifo_victim_pick #(
    parameter int WAYS  = 8,
    parameter int IDX_W = 3,
    parameter int AGE_W = 3
) (
    input  logic [WAYS-1:0]       active,
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS-1:0]       lock,
    input  logic [WAYS*AGE_W-1:0] age_flat,
    output logic [IDX_W-1:0]      way,
    output logic                  none,
    output logic                  free_found
);
    logic             old_found;
    logic [AGE_W-1:0] best_age;

    always_comb begin
        free_found = 1'b0;
        old_found  = 1'b0;
        best_age   = '0;
        way        = '0;
        // Scan downwards so that the lowest free index wins
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (active[w] && !valid[w]) begin
                free_found = 1'b1;
                way        = IDX_W'(w);
            end
        end
        if (!free_found) begin
            // Strictly greater keeps the lowest index on equal ages
            for (int w = 0; w < WAYS; w++) begin
                if (active[w] && !lock[w] &&
                    (!old_found || age_flat[w*AGE_W +: AGE_W] > best_age)) begin
                    old_found = 1'b1;
                    best_age  = age_flat[w*AGE_W +: AGE_W];
                    way       = IDX_W'(w);
                end
            end
        end
        none = !free_found && !old_found;
    end
endmodule

// File: rtl/lkfifo_way_repl.sv
module lkfifo_way_repl
    import lkfifo_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MAX_WAYS = 8,
    localparam int IDX_W   = $clog2(MAX_WAYS),
    localparam int AGE_W   = IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_eight,
    input  logic                      fill_req,
    input  logic [ADDR_W-1:0]         fill_addr,
    input  logic                      fill_dirty,
    input  logic                      mark_req,
    input  logic [IDX_W-1:0]          mark_way,
    input  logic                      unlock_req,
    input  logic [ADDR_W-1:0]         unlock_addr,
    input  logic [ADDR_W-1:0]         unlock_size,
    input  logic                      inv_all,
    input  logic                      lk0_en,
    input  logic [ADDR_W-1:0]         lk0_base,
    input  logic [ADDR_W-1:0]         lk0_size,
    input  logic                      lk1_en,
    input  logic [ADDR_W-1:0]         lk1_base,
    input  logic [ADDR_W-1:0]         lk1_size,
    output logic [IDX_W-1:0]          victim_way,
    output logic                      victim_dirty,
    output logic                      victim_none,
    output logic [MAX_WAYS-1:0]       way_valid,
    output logic [MAX_WAYS-1:0]       way_dirty,
    output logic [MAX_WAYS-1:0]       way_locked,
    output logic [MAX_WAYS*AGE_W-1:0] way_age
);
    localparam int NUM_WIN   = 2;
    localparam int HALF_WAYS = MAX_WAYS / 2;

    typedef struct packed {
        logic [MAX_WAYS-1:0]              valid;
        logic [MAX_WAYS-1:0]              dirty;
        logic [MAX_WAYS-1:0]              lock;
        logic [MAX_WAYS-1:0][AGE_W-1:0]   age;
        logic [MAX_WAYS-1:0][ADDR_W-1:0]  tag;
    } set_state_t;

    set_state_t st_d, st_q;
    set_op_e    op;

    logic [MAX_WAYS-1:0] active;
    logic [MAX_WAYS-1:0] unl_hit;
    logic [NUM_WIN-1:0]  win_en;
    logic [NUM_WIN-1:0]  win_hit;
    logic [ADDR_W-1:0]   win_base [NUM_WIN];
    logic [ADDR_W-1:0]   win_size [NUM_WIN];
    logic [IDX_W-1:0]    pick_way;
    logic                pick_none;
    logic                pick_free;
    logic [AGE_W-1:0]    top_age;

    assign win_en      = {lk1_en, lk0_en};
    assign win_base[0] = lk0_base;
    assign win_base[1] = lk1_base;
    assign win_size[0] = lk0_size;
    assign win_size[1] = lk1_size;

    // Lock windows, checked against the fill address
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        lkfifo_addr_window #(.ADDR_W(ADDR_W)) win_i (
            .enable (win_en[g]),
            .addr   (fill_addr),
            .base   (win_base[g]),
            .size   (win_size[g]),
            .hit    (win_hit[g])
        );
    end

    // Per-way active mask and unlock range match
    for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
        assign active[w] = mode_eight || (w < HALF_WAYS);
        lkfifo_addr_window #(.ADDR_W(ADDR_W)) unl_i (
            .enable (1'b1),
            .addr   (st_q.tag[w]),
            .base   (unlock_addr),
            .size   (unlock_size),
            .hit    (unl_hit[w])
        );
    end

    lkfifo_victim_pick #(.WAYS(MAX_WAYS), .IDX_W(IDX_W), .AGE_W(AGE_W)) pick_i (
        .active     (active),
        .valid      (st_q.valid),
        .lock       (st_q.lock),
        .age_flat   (st_q.age),
        .way        (pick_way),
        .none       (pick_none),
        .free_found (pick_free)
    );

    // Operation priority: invalidate, fill, unlock, mark
    always_comb begin
        if (inv_all)         op = OP_INV;
        else if (fill_req)   op = OP_FILL;
        else if (unlock_req) op = OP_UNLOCK;
        else if (mark_req)   op = OP_MARK;
        else                 op = OP_IDLE;
    end

    always_comb begin
        st_d    = st_q;
        top_age = mode_eight ? AGE_W'(MAX_WAYS - 1) : AGE_W'(HALF_WAYS - 1);
        case (op)
            OP_INV: st_d.valid = '0;
            OP_FILL: begin
                if (!pick_none) begin
                    for (int w = 0; w < MAX_WAYS; w++) begin
                        if (active[w] && st_q.valid[w] && !st_q.lock[w] &&
                            IDX_W'(w) != pick_way && st_q.age[w] < top_age) begin
                            st_d.age[w] = st_q.age[w] + 1'b1;
                        end
                    end
                    st_d.valid[pick_way] = 1'b1;
                    st_d.dirty[pick_way] = fill_dirty;
                    st_d.lock[pick_way]  = |win_hit;
                    st_d.age[pick_way]   = '0;
                    st_d.tag[pick_way]   = fill_addr;
                end
            end
            OP_UNLOCK: begin
                for (int w = 0; w < MAX_WAYS; w++) begin
                    if (st_q.valid[w] && unl_hit[w]) st_d.lock[w] = 1'b0;
                end
            end
            OP_MARK: begin
                if (st_q.valid[mark_way] && active[mark_way]) st_d.dirty[mark_way] = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_way   = pick_way;
    assign victim_none  = pick_none;
    assign victim_dirty = !pick_none && !pick_free && st_q.dirty[pick_way];
    assign way_valid    = st_q.valid;
    assign way_dirty    = st_q.dirty;
    assign way_locked   = st_q.lock;
    assign way_age      = st_q.age;

    a_r1_low_ways_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !mode_eight && !victim_none) |-> (victim_way < IDX_W'(HALF_WAYS)));

    a_r2_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && |(active & ~st_q.valid)) |-> !st_q.valid[victim_way]);

    a_r3_fill_youngest: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !inv_all && !victim_none) |=>
        (st_q.valid[$past(victim_way)] && st_q.age[$past(victim_way)] == '0));

    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_req && !unlock_req) |=> $stable(way_locked));

    a_r8_none_only_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        victim_none |-> ((st_q.valid & st_q.lock & active) == active));

    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (way_valid == '0));
endmodule

// File: tb/lkfifo_way_repl_tb.sv
module lkfifo_way_repl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_eight, fill_req, fill_dirty, mark_req, unlock_req, inv_all;
    logic [AW-1:0] fill_addr, unlock_addr, unlock_size;
    logic [2:0]    mark_way;
    logic          lk0_en, lk1_en;
    logic [AW-1:0] lk0_base, lk0_size, lk1_base, lk1_size;
    logic [2:0]    victim_way;
    logic          victim_dirty, victim_none;
    logic [MW-1:0] way_valid, way_dirty, way_locked;
    logic [MW*3-1:0] way_age;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Reference model of the set
    bit mv [MW];
    bit md [MW];
    bit ml [MW];
    int ma [MW];
    int mt [MW];

    always #(CLK_PERIOD/2) clk = ~clk;

    lkfifo_way_repl #(.ADDR_W(AW), .MAX_WAYS(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_eight(mode_eight),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .mark_req(mark_req), .mark_way(mark_way),
        .unlock_req(unlock_req), .unlock_addr(unlock_addr), .unlock_size(unlock_size),
        .inv_all(inv_all),
        .lk0_en(lk0_en), .lk0_base(lk0_base), .lk0_size(lk0_size),
        .lk1_en(lk1_en), .lk1_base(lk1_base), .lk1_size(lk1_size),
        .victim_way(victim_way), .victim_dirty(victim_dirty), .victim_none(victim_none),
        .way_valid(way_valid), .way_dirty(way_dirty), .way_locked(way_locked),
        .way_age(way_age)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int n_act();
        return mode_eight ? 8 : 4;
    endfunction

    function automatic bit in_rng(input int a, input int b, input int s);
        return (a >= b) && (a < b + s);
    endfunction

    task automatic model_pick(output int v, output bit none, output bit free);
        v = -1; free = 0; none = 0;
        for (int w = 0; w < n_act(); w++)
            if (!mv[w] && !free) begin v = w; free = 1; end
        if (!free) begin
            for (int w = 0; w < n_act(); w++)
                if (!ml[w] && (v < 0 || ma[w] > ma[v])) v = w;
            none = (v < 0);
        end
    endtask

    task automatic check_state(input string req);
        logic [MW-1:0] ev, ed, el;
        for (int w = 0; w < MW; w++) begin
            ev[w] = mv[w]; ed[w] = md[w]; el[w] = ml[w];
        end
        chk({req, " way_valid"}, way_valid, ev);
        chk({req, " way_dirty"}, way_dirty, ed);
        chk({req, " way_locked"}, way_locked, el);
        for (int w = 0; w < MW; w++)
            if (mv[w]) chk("R3 age", way_age[w*3 +: 3], ma[w]);
    endtask

    // All tasks start and end at a falling edge
    task automatic do_fill(input int a, input bit d);
        int v; bit none, free, lk;
        fill_req = 1; fill_addr = AW'(a); fill_dirty = d;
        #1;
        model_pick(v, none, free);
        chk("R8 victim_none", victim_none, none);
        if (!none) begin
            chk(free ? "R2 victim_way" : "R3 victim_way", victim_way, v);
            chk("R4 victim_dirty", victim_dirty, free ? 0 : md[v]);
            if (!mode_eight) chk("R1 victim below 4", victim_way < 4, 1);
        end
        lk = (lk0_en && in_rng(a, lk0_base, lk0_size)) || (lk1_en && in_rng(a, lk1_base, lk1_size));
        @(posedge clk);
        if (!none) begin
            for (int w = 0; w < n_act(); w++)
                if (w != v && mv[w] && !ml[w] && ma[w] < n_act() - 1) ma[w]++;
            mv[v] = 1; md[v] = d; ml[v] = lk; ma[v] = 0; mt[v] = a;
        end
        @(negedge clk);
        fill_req = 0;
        check_state(lk ? "R5 fill" : "R3 fill");
    endtask

    task automatic do_mark(input int w);
        mark_req = 1; mark_way = 3'(w);
        @(posedge clk);
        if (mv[w] && w < n_act()) md[w] = 1;
        @(negedge clk);
        mark_req = 0;
        check_state("R4 mark");
    endtask

    task automatic do_unlock(input int a, input int s);
        unlock_req = 1; unlock_addr = AW'(a); unlock_size = AW'(s);
        @(posedge clk);
        for (int w = 0; w < MW; w++)
            if (mv[w] && in_rng(mt[w], a, s)) ml[w] = 0;
        @(negedge clk);
        unlock_req = 0;
        check_state("R7 unlock");
    endtask

    task automatic do_inv(input bit with_fill);
        inv_all = 1; fill_req = with_fill; fill_addr = 16'h0777; fill_dirty = 1;
        @(posedge clk);
        for (int w = 0; w < MW; w++) mv[w] = 0;
        @(negedge clk);
        inv_all = 0; fill_req = 0;
        check_state("R9 invalidate");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_eight = 0; fill_req = 0; fill_dirty = 0; fill_addr = '0;
        mark_req = 0; mark_way = '0; unlock_req = 0; unlock_addr = '0; unlock_size = '0;
        inv_all = 0; lk0_en = 0; lk1_en = 0;
        lk0_base = 16'h0100; lk0_size = 16'h0010; lk1_base = 16'h0200; lk1_size = 16'h0004;
        for (int w = 0; w < MW; w++) begin mv[w] = 0; md[w] = 0; ml[w] = 0; ma[w] = 0; mt[w] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R10 reset");
        chk("R10 reset ages", way_age, 0);

        // Fill streams in both modes
        for (int m = 0; m < 2; m++) begin
            mode_eight = m[0];
            do_inv(0);
            lk0_en = 1; lk1_en = 1;
            for (int i = 0; i < 48; i++) begin
                int a;
                if (i == 20) lk0_en = 0;  // R6: window off, pinned lines stay pinned
                if (i % 6 == 4) do_mark(i % n_act());
                if (i == 30) do_unlock(16'h0100, 16'h0010);
                if (i % 9 == 2)       a = 16'h0100 + (i % 16);
                else if (i % 13 == 7) a = 16'h0200 + (i % 4);
                else                  a = 16'h0400 + i * 19;
                do_fill(a, i % 3 == 0);
                if (i == 20) check_state("R6 window disabled");
            end
            if (m == 0) chk("R1 upper ways unused", way_valid[7:4], 0);
        end

        // Every active way pinned: fill refused
        mode_eight = 0;
        do_inv(0);
        lk0_en = 1; lk1_en = 0;
        for (int i = 0; i < 4; i++) do_fill(16'h0100 + i, 0);
        chk("R5 all four pinned", way_locked[3:0], 4'hF);
        do_fill(16'h0500, 1);
        chk("R8 no victim", victim_none, 1);
        do_unlock(16'h0102, 16'h0001);
        do_fill(16'h0500, 1);
        chk("R7 released way reused", way_locked[3:0], 4'hB);

        // Invalidate wins over a same-cycle fill
        do_inv(1);
        chk("R9 priority over fill", way_valid, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule